// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block is a passive monitor placed beside a DDR3-style command bus that serves a pair of ranks. On every clock it samples one command, together with the bank and rank it targets. It keeps just enough history to judge whether that command came too soon after earlier ones. When a command breaks one of the spacing rules, the monitor raises a one-cycle violation flag and a 3-bit code that names the broken rule. It never stalls or alters the stream.

Six rules are checked side by side:
- the row cycle between two activates to the same bank;
- a sliding window that admits at most four activates;
- the write-to-read turnaround on one rank;
- the read-to-write turnaround;
- the gap needed when a read on one rank is followed by an access to the other rank;
- the blackout that follows a refresh.

Every timing value is a parameter counted in clocks. A burst is 8 beats, which is `BURST_CLK` = 4 clocks of data.

Two small state machines do the work, with per-bank down-counters and a timestamp window alongside them.

The bus turnaround machine has three states:
- `BUS_IDLE`: no recent column command.
- `BUS_AFTER_RD`: the last column command was a read.
- `BUS_AFTER_WR`: the last column command was a write.

A read takes it to `BUS_AFTER_RD`, and a write takes it to `BUS_AFTER_WR`, from any state. It goes back to `BUS_IDLE` once every turnaround gap has run out.

The refresh machine has two states:
- `REF_OPEN`: commands are allowed.
- `REF_BLACKOUT`: only NOP is allowed.

A refresh takes it to `REF_BLACKOUT`, and a further refresh reloads the blackout. It goes back to `REF_OPEN` when the blackout count expires.

Top module: `dram_cmd_timing_checker`

## Requirements
- R1: Synchronous active-high `rst` clears all history and both outputs. A command presented in the first cycle after reset is never flagged.
- R2: An activate (command code 1) to a bank is flagged with code 1 when fewer than `T_RC` clocks separate it from the previous activate to the same bank of the same rank. Here, bank means the pair {rank, bank}. Activates to other banks do not count.
- R3: An activate is flagged with code 2 when four earlier activates exist and the oldest of the last four lies fewer than `T_FAW` clocks back. The window counts activates across all banks and both ranks.
- R4: A read (code 2) is flagged with code 3 when the last column command was a write (code 3) to the same rank, fewer than `CWL + BURST_CLK + T_WTR` clocks earlier.
- R5: A write is flagged with code 4 when the last column command was a read to any rank, fewer than `CL + BURST_CLK + 1 - CWL` clocks earlier. The limit is at least 1.
- R6: A read or a write is flagged with code 5 when the last column command was a read to the other rank, fewer than `BURST_CLK + T_RANK_GAP` clocks earlier.
- R7: After a refresh (code 4), any command other than NOP is flagged with code 6 until `T_RFC` clocks have passed. NOP is code 0, and codes 6 and 7 act as NOP. Precharge is code 5.
- R8: When several rules are broken at once, the reported code follows this priority: refresh (6), row cycle (1), activate window (2), write-to-read (3), read-to-write (4), rank gap (5).
- R9: `viol_o` is high for exactly the one cycle after the offending command. `viol_code_o` is nonzero exactly when `viol_o` is high.
- R10: Every command updates the history, flagged or not. Precharge and NOP take part in no rule except the refresh blackout, which applies to precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the command bus |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 activate, 2 read, 3 write, 4 refresh, 5 precharge |
| bank_i | input | BANK_W | Target bank |
| rank_i | input | RANK_W | Target rank |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Broken rule: 1 row cycle, 2 window, 3 write-to-read, 4 read-to-write, 5 rank gap, 6 refresh; 0 when idle |

## Verification
The assertions assume that at most one command arrives per clock and that the timing parameters are at least 2 clocks. The per-bank counters and the refresh blackout rely on that minimum. The random stimulus draws exactly one command per cycle, using only the six defined encodings, with NOP favoured so that both legal and early spacings occur often. Directed sequences place commands one clock either side of each limit. They also stack rules to exercise the priority order.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_REF  = 3'd4,
        CMD_PRE  = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } dram_cmd_e;

    typedef enum logic [2:0] {
        VC_NONE    = 3'd0,
        VC_ROWCYC  = 3'd1,
        VC_ACTWIN  = 3'd2,
        VC_WR2RD   = 3'd3,
        VC_RD2WR   = 3'd4,
        VC_RANKSW  = 3'd5,
        VC_REFRESH = 3'd6
    } viol_code_e;

endpackage

// File: rtl/dtc_row_cycle.sv
module dtc_row_cycle #(
    parameter int SLOT_W = 4,
    parameter int T_RC   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              hit_o
);
    localparam int NUM_SLOTS = 2 ** SLOT_W;
    localparam int RC_W      = $clog2(T_RC + 1);

    logic [RC_W-1:0] left_q [NUM_SLOTS];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    left_q[g] <= '0;
                end else if (act_i && slot_i == SLOT_W'(g)) begin
                    left_q[g] <= RC_W'(T_RC - 1);
                end else if (left_q[g] != '0) begin
                    left_q[g] <= left_q[g] - 1'b1;
                end
            end

            // R2
            rc_load_chk: assert property (@(posedge clk) disable iff (rst)
                (act_i && slot_i == SLOT_W'(g)) |=> (left_q[g] == RC_W'(T_RC - 1)));
        end
    endgenerate

    assign hit_o = act_i && (left_q[slot_i] != '0);

endmodule

// File: rtl/dtc_act_window.sv
module dtc_act_window #(
    parameter int T_FAW     = 24,
    parameter int ACT_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(T_FAW + 2) + 1;

    logic [CNT_W-1:0]     now_q;
    logic [CNT_W-1:0]     stamp_q [ACT_LIMIT];
    logic [ACT_LIMIT-1:0] valid_q;
    logic [CNT_W-1:0]     age     [ACT_LIMIT];
    logic [ACT_LIMIT-1:0] stale;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    generate
        for (genvar i = 0; i < ACT_LIMIT; i++) begin : g_age
            assign age[i]   = now_q - stamp_q[i];
            assign stale[i] = age[i] >= CNT_W'(T_FAW);
        end

        for (genvar i = 0; i < ACT_LIMIT; i++) begin : g_entry
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stamp_q[0] <= '0;
                        valid_q[0] <= 1'b0;
                    end else if (act_i) begin
                        stamp_q[0] <= now_q;
                        valid_q[0] <= 1'b1;
                    end else begin
                        valid_q[0] <= valid_q[0] && !stale[0];
                    end
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stamp_q[i] <= '0;
                        valid_q[i] <= 1'b0;
                    end else if (act_i) begin
                        stamp_q[i] <= stamp_q[i-1];
                        valid_q[i] <= valid_q[i-1] && !stale[i-1];
                    end else begin
                        valid_q[i] <= valid_q[i] && !stale[i];
                    end
                end
            end
        end
    endgenerate

    assign hit_o = act_i && valid_q[ACT_LIMIT-1] && (age[ACT_LIMIT-1] < CNT_W'(T_FAW));

    // R3
    faw_full_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ($countones(valid_q) == ACT_LIMIT));

endmodule

// File: rtl/dtc_bus_turn.sv
module dtc_bus_turn #(
    parameter int RANK_W = 1,
    parameter int G_WTR  = 13,
    parameter int G_RTW  = 6,
    parameter int G_RANK = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [RANK_W-1:0] rank_i,
    output logic              wtr_hit_o,
    output logic              rtw_hit_o,
    output logic              rank_hit_o
);
    localparam int G_HI  = (G_WTR > G_RTW) ? G_WTR : G_RTW;
    localparam int G_MAX = (G_HI > G_RANK) ? G_HI : G_RANK;
    localparam int CNT_W = $clog2(G_MAX + 1);

    typedef enum logic [1:0] {
        BUS_IDLE     = 2'd0,
        BUS_AFTER_RD = 2'd1,
        BUS_AFTER_WR = 2'd2
    } bus_state_e;

    bus_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [RANK_W-1:0] last_rank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= BUS_IDLE;
            cnt_q       <= '0;
            last_rank_q <= '0;
        end else begin
            state_q <= state_n;
            if (rd_i || wr_i) begin
                cnt_q       <= CNT_W'(1);
                last_rank_q <= rank_i;
            end else if (cnt_q < CNT_W'(G_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_AFTER_RD,
            BUS_AFTER_WR: if (cnt_q >= CNT_W'(G_MAX - 1)) state_n = BUS_IDLE;
            default:      state_n = BUS_IDLE;
        endcase
        if (rd_i)      state_n = BUS_AFTER_RD;
        else if (wr_i) state_n = BUS_AFTER_WR;
    end

    always_comb begin
        wtr_hit_o  = 1'b0;
        rtw_hit_o  = 1'b0;
        rank_hit_o = 1'b0;
        unique case (state_q)
            BUS_AFTER_RD: begin
                rtw_hit_o  = wr_i && (cnt_q < CNT_W'(G_RTW));
                rank_hit_o = (rd_i || wr_i) && (rank_i != last_rank_q)
                             && (cnt_q < CNT_W'(G_RANK));
            end
            BUS_AFTER_WR: begin
                wtr_hit_o = rd_i && (rank_i == last_rank_q) && (cnt_q < CNT_W'(G_WTR));
            end
            default: ;
        endcase
    end

    // R4
    col_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i || wr_i) |=> (state_q != BUS_IDLE));

    // R5
    rd_sets_state_chk: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (state_q == BUS_AFTER_RD && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/dram_cmd_timing_checker.sv
module dram_cmd_timing_checker
    import dtc_pkg::*;
#(
    parameter int BANK_W     = 3,
    parameter int RANK_W     = 1,
    parameter int T_RC       = 20,
    parameter int T_FAW      = 24,
    parameter int ACT_LIMIT  = 4,
    parameter int T_WTR      = 4,
    parameter int T_RFC      = 40,
    parameter int T_RANK_GAP = 2,
    parameter int CL         = 6,
    parameter int CWL        = 5,
    parameter int BURST_CLK  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [RANK_W-1:0] rank_i,
    output logic              viol_o,
    output logic [2:0]        viol_code_o
);
    localparam int SLOT_W     = BANK_W + RANK_W;
    localparam int G_WTR      = CWL + BURST_CLK + T_WTR;
    localparam int G_RTW_RAW  = CL + BURST_CLK + 1 - CWL;
    localparam int G_RTW      = (G_RTW_RAW < 1) ? 1 : G_RTW_RAW;
    localparam int G_RANK     = BURST_CLK + T_RANK_GAP;
    localparam int RFC_W      = $clog2(T_RFC + 1);

    typedef enum logic {
        REF_OPEN     = 1'b0,
        REF_BLACKOUT = 1'b1
    } ref_state_e;

    dram_cmd_e  cmd;
    logic       is_act, is_rd, is_wr, is_ref, is_real;
    logic       rc_hit, faw_hit, wtr_hit, rtw_hit, rank_hit, ref_hit;
    ref_state_e ref_state_q, ref_state_n;
    logic [RFC_W-1:0] ref_left_q;
    viol_code_e code_n, code_q;
    logic       viol_q;

    assign cmd     = dram_cmd_e'(cmd_i);
    assign is_act  = (cmd == CMD_ACT);
    assign is_rd   = (cmd == CMD_RD);
    assign is_wr   = (cmd == CMD_WR);
    assign is_ref  = (cmd == CMD_REF);
    assign is_real = cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_REF, CMD_PRE};

    dtc_row_cycle #(.SLOT_W(SLOT_W), .T_RC(T_RC)) u_row_cycle (
        .clk    (clk),
        .rst    (rst),
        .act_i  (is_act),
        .slot_i ({rank_i, bank_i}),
        .hit_o  (rc_hit)
    );

    dtc_act_window #(.T_FAW(T_FAW), .ACT_LIMIT(ACT_LIMIT)) u_act_window (
        .clk   (clk),
        .rst   (rst),
        .act_i (is_act),
        .hit_o (faw_hit)
    );

    dtc_bus_turn #(.RANK_W(RANK_W), .G_WTR(G_WTR), .G_RTW(G_RTW), .G_RANK(G_RANK)) u_bus_turn (
        .clk        (clk),
        .rst        (rst),
        .rd_i       (is_rd),
        .wr_i       (is_wr),
        .rank_i     (rank_i),
        .wtr_hit_o  (wtr_hit),
        .rtw_hit_o  (rtw_hit),
        .rank_hit_o (rank_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_state_q <= REF_OPEN;
            ref_left_q  <= '0;
        end else begin
            ref_state_q <= ref_state_n;
            if (is_ref)                ref_left_q <= RFC_W'(T_RFC - 1);
            else if (ref_left_q != '0) ref_left_q <= ref_left_q - 1'b1;
        end
    end

    always_comb begin
        ref_state_n = ref_state_q;
        unique case (ref_state_q)
            REF_OPEN:     if (is_ref) ref_state_n = REF_BLACKOUT;
            REF_BLACKOUT: if (!is_ref && ref_left_q <= RFC_W'(1)) ref_state_n = REF_OPEN;
            default:      ref_state_n = REF_OPEN;
        endcase
    end

    assign ref_hit = (ref_state_q == REF_BLACKOUT) && is_real;

    always_comb begin
        if (ref_hit)       code_n = VC_REFRESH;
        else if (rc_hit)   code_n = VC_ROWCYC;
        else if (faw_hit)  code_n = VC_ACTWIN;
        else if (wtr_hit)  code_n = VC_WR2RD;
        else if (rtw_hit)  code_n = VC_RD2WR;
        else if (rank_hit) code_n = VC_RANKSW;
        else               code_n = VC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q <= 1'b0;
            code_q <= VC_NONE;
        end else begin
            viol_q <= (code_n != VC_NONE);
            code_q <= code_n;
        end
    end

    assign viol_o      = viol_q;
    assign viol_code_o = code_q;

    // R1
    post_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> !viol_o);

    // R7
    ref_blackout_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_state_q == REF_BLACKOUT && is_real) |=> (viol_o && viol_code_o == VC_REFRESH));

    // R8
    rc_over_faw_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_hit && rc_hit) |=> (viol_code_o == VC_ROWCYC));

    // R9
    code_pair_chk: assert property (@(posedge clk) disable iff (rst)
        viol_o == (viol_code_o != VC_NONE));

    // R9
    clean_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(ref_hit || rc_hit || faw_hit || wtr_hit || rtw_hit || rank_hit) |=> !viol_o);

endmodule

// File: tb/tb_dram_cmd_timing_checker.sv
`timescale 1ns/1ps
module tb_dram_cmd_timing_checker;
    localparam int T_RC = 20, T_FAW = 24, FAW_N = 4, T_WTR = 4, T_RFC = 40;
    localparam int T_RANK_GAP = 2, CL = 6, CWL = 5, BURST_CLK = 4;
    localparam int G_WTR  = CWL + BURST_CLK + T_WTR;
    localparam int G_RTW  = (CL + BURST_CLK + 1 - CWL < 1) ? 1 : CL + BURST_CLK + 1 - CWL;
    localparam int G_RANK = BURST_CLK + T_RANK_GAP;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic [2:0] bank = 3'd0;
    logic       rank = 1'b0;
    logic       viol;
    logic [2:0] code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int last_act [16];
    bit act_seen [16];
    int acts [FAW_N];
    int nacts, col_t, col_kind, col_rank, ref_t, now_t, pend;
    bit col_seen, ref_seen;

    dram_cmd_timing_checker #(
        .BANK_W(3), .RANK_W(1), .T_RC(T_RC), .T_FAW(T_FAW), .ACT_LIMIT(FAW_N),
        .T_WTR(T_WTR), .T_RFC(T_RFC), .T_RANK_GAP(T_RANK_GAP), .CL(CL), .CWL(CWL),
        .BURST_CLK(BURST_CLK)
    ) dut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .rank_i(rank),
        .viol_o(viol), .viol_code_o(code)
    );

    always #5 clk = ~clk;

    function automatic string req_of(input int c);
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) act_seen[i] = 1'b0;
        nacts = 0; col_seen = 1'b0; ref_seen = 1'b0; pend = 0; now_t = 0;
    endtask

    task automatic predict(input int c, input int b, input int r, output int e);
        int slot = r * 8 + b;
        int gap  = now_t - col_t;
        bit real_cmd = (c >= 1 && c <= 5);
        e = 0;
        if (ref_seen && now_t - ref_t < T_RFC && real_cmd) e = 6;
        else if (c == 1 && act_seen[slot] && now_t - last_act[slot] < T_RC) e = 1;
        else if (c == 1 && nacts >= FAW_N && now_t - acts[FAW_N-1] < T_FAW) e = 2;
        else if (c == 2 && col_seen && col_kind == 3 && col_rank == r && gap < G_WTR) e = 3;
        else if (c == 3 && col_seen && col_kind == 2 && gap < G_RTW) e = 4;
        else if ((c == 2 || c == 3) && col_seen && col_kind == 2 && col_rank != r && gap < G_RANK) e = 5;
        // R10: history follows every command, flagged or not
        if (c == 1) begin
            last_act[slot] = now_t; act_seen[slot] = 1'b1;
            for (int i = FAW_N - 1; i > 0; i--) acts[i] = acts[i-1];
            acts[0] = now_t; nacts++;
        end
        if (c == 2 || c == 3) begin
            col_seen = 1'b1; col_kind = c; col_rank = r; col_t = now_t;
        end
        if (c == 4) begin
            ref_seen = 1'b1; ref_t = now_t;
        end
        now_t++;
    endtask

    task automatic compare_pending();
        checks++;
        if (viol !== (pend != 0) || code !== 3'(pend)) begin
            fails++;
            $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
                     req_of(pend), viol, code, pend != 0, pend);
        end
    endtask

    task automatic step(input int c, input int b, input int r);
        int e;
        @(negedge clk);
        compare_pending();
        cmd = 3'(c); bank = 3'(b); rank = 1'(r);
        predict(c, b, r, e);
        pend = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare_pending();
        rst = 1'b1; cmd = 3'd0;
        repeat (2) @(negedge clk);
        checks++;
        if (viol !== 1'b0 || code !== 3'd0) begin
            fails++;
            $display("FAIL R1: viol=%0b code=%0d expected viol=0 code=0", viol, code);
        end
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(64'd2_000_000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();

        // R1: activate right after reset, then an immediate repeat (R2)
        step(1, 0, 0);
        step(1, 0, 0);
        idle(T_RC);

        // R2 boundary and R10: flagged activate still restarts the row cycle
        step(1, 3, 1);
        idle(T_RC - 2);
        step(1, 3, 1);
        idle(T_RC - 2);
        step(1, 3, 1);
        step(5, 3, 1);
        idle(T_RC - 2);
        step(1, 3, 1);
        idle(50);

        // R3: fifth activate inside the window
        for (int b = 1; b <= 5; b++) step(1, b, 0);
        idle(50);
        // R3 boundary: fifth activate exactly T_FAW after the first
        for (int b = 1; b <= 4; b++) step(1, b, 1);
        idle(T_FAW - 4);
        step(1, 6, 1);
        idle(50);

        // R8: row cycle outranks the window
        for (int b = 1; b <= 4; b++) step(1, b, 0);
        step(1, 1, 0);
        idle(50);

        // R4 boundary, and a write on the other rank followed by a read
        step(3, 0, 0); idle(G_WTR - 2); step(2, 0, 0); idle(20);
        step(3, 0, 0); idle(G_WTR - 1); step(2, 0, 0); idle(20);
        step(3, 0, 0); step(2, 0, 1); idle(20);

        // R5 boundary
        step(2, 0, 0); idle(G_RTW - 2); step(3, 0, 0); idle(20);
        step(2, 0, 0); idle(G_RTW - 1); step(3, 0, 0); idle(20);

        // R6 boundary
        step(2, 0, 0); idle(G_RANK - 2); step(2, 0, 1); idle(20);
        step(2, 0, 0); idle(G_RANK - 1); step(2, 0, 1); idle(20);

        // R7 boundary and R8 precedence over the row cycle
        step(1, 7, 0); step(4, 0, 0); step(1, 7, 0);
        idle(T_RFC - 3); step(5, 0, 0);
        idle(T_RFC - 1); step(1, 2, 1);
        idle(50);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 16);
            int c;
            if (r < 8)       c = 0;
            else if (r < 11) c = 1;
            else if (r < 13) c = 2;
            else if (r < 14) c = 3;
            else if (r < 15) c = 5;
            else             c = ($urandom % 6 == 0) ? 4 : 0;
            step(c, int'($urandom % 8), int'($urandom % 2));
        end

        // R1: mid-run reset wipes history
        step(1, 4, 0);
        do_reset();
        step(1, 4, 0);
        step(2, 0, 0);
        idle(3);

        @(negedge clk);
        compare_pending();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule